// File: doc/BRIEF.md
# Video Palette Control Register Bank

This block holds the control registers of a palette-based video output stage. A host writes a register through a 4-bit select bus, a data bus and an asynchronous write strobe. The block brings the strobe into the system clock domain and acts once on each rising edge of it. Register contents can be read back at any time by driving the select bus and observing the read data bus.

The bank returns to its default mode from three sources. The first is an active-low power-on input. The second is a strobe issued with the select bus at all ones, which resets the bank and writes nothing. The third is a write of the default mode code into the mux control register. Each reset also produces a clear for the external shift-clock and video-clock counters.

The block also forms the address that goes to the palette RAM. In nibble mode, the page register supplies the upper address bits. The result is then gated bit by bit by the pixel read mask.

Top module: `vdc_regbank`

## Requirements
- R1: While `por_n` is low, and after it is released, the registers read back as follows: mux control 8'h2D, input clock select 8'h00, output clock select 8'h3F, page 8'h00, general control 8'h03, read mask 8'hFF, and test 8'h00 (test value 0 selects the red component).
- R2: A rising edge of `wr_strobe` with `sel` in 0..8 stores `wdata` into the selected register. The write takes effect on the third rising clock edge after the strobe rises. The select map is: 0 palette address, 1 holding, 2 read mask, 3 page, 4 general control, 5 input clock select, 6 output clock select, 7 mux control, 8 test. `rdata` shows the register selected by `sel`.
- R3: Selects 9..14 read as zero, and writes to them change no register.
- R4: A strobe rising edge with `sel` = 4'hF restores every register named in R1 to its default value and writes no register.
- R5: A write to select 7 whose bits [5:0] equal 6'h2D restores all R1 defaults, so the mux control register reads 8'h2D even when `wdata` bits [7:6] are set.
- R6: A write to select 7 whose bits [5:0] differ from 6'h2D is stored as written and causes no reset.
- R7: `cnt_clr` is high while `por_n` is low and for exactly one cycle after release. After a hardware or software reset it is high for exactly one cycle, starting on the edge where the reset takes effect. It stays low after ordinary writes.
- R8: When general control bit 2 is 0, `pal_addr` = `pix_addr` & mask.
- R9: When general control bit 2 is 1, `pal_addr` = {page[7:4], pix_addr[3:0]} & mask.
- R10: A read mask of zero forces `pal_addr` to 0 whatever the page and mode.
- R11: A strobe held high causes a single action. Changing `wdata` while the strobe stays high has no effect until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; asserts asynchronously and releases synchronously |
| sel | input | 4 | Register select |
| wdata | input | 8 | Write data |
| wr_strobe | input | 1 | Asynchronous write strobe; acts on its rising edge |
| pix_addr | input | 8 | Pixel palette index |
| rdata | output | 8 | Read data of the selected register |
| pal_addr | output | 8 | Palette RAM address after page merge and mask |
| cnt_clr | output | 1 | Clear pulse for the shift-clock and video-clock counters |

## Verification
The assertions assume that `sel` and `wdata` stay stable from the moment the strobe rises until the synchronised edge has acted, three clock edges later. They also assume the strobe stays low long enough for the synchroniser to see it low before it rises again. The bench always sets select and data on a falling clock edge together with the strobe. It holds them for several cycles beyond the action edge and keeps the strobe low for three cycles between writes. The only exception is the deliberate held-strobe test for R11, where the data changes only after the action has happened.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
   // select codes (bank map)
   localparam int unsigned SEL_PADDR  = 0;
   localparam int unsigned SEL_HOLD   = 1;
   localparam int unsigned SEL_MASK   = 2;
   localparam int unsigned SEL_PAGE   = 3;
   localparam int unsigned SEL_GCTL   = 4;
   localparam int unsigned SEL_ICLK   = 5;
   localparam int unsigned SEL_OCLK   = 6;
   localparam int unsigned SEL_MUX    = 7;
   localparam int unsigned SEL_TEST   = 8;

   // default register contents
   localparam logic [7:0] DEF_MUX  = 8'h2D;
   localparam logic [7:0] DEF_ICLK = 8'h00;
   localparam logic [7:0] DEF_OCLK = 8'h3F;
   localparam logic [7:0] DEF_PAGE = 8'h00;
   localparam logic [7:0] DEF_GCTL = 8'h03;
   localparam logic [7:0] DEF_MASK = 8'hFF;
   localparam logic [7:0] DEF_TEST = 8'h00;  // red component

   // mux code that doubles as a software reset
   localparam logic [5:0] MUX_RST_CODE = 6'h2D;
   // general control bit that enables nibble (paged) mode
   localparam int unsigned GCTL_NIB_BIT = 2;
endpackage

// File: rtl/vdc_sync.sv
module vdc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("vdc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/vdc_regfile.sv
module vdc_regfile
   import vdc_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_rise,
   input  logic [SW-1:0] sel,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] mask_q,
   output logic [DW-1:0] page_q,
   output logic [DW-1:0] gctl_q,
   output logic [DW-1:0] mux_q,
   output logic          cnt_clr
);
   localparam logic [SW-1:0] SEL_ALL1 = {SW{1'b1}};

   logic [DW-1:0] paddr_q, hold_q, iclk_q, oclk_q, test_q;
   logic          hw_rst, sw_rst, bank_rst, clr_q;

   assign hw_rst   = wr_rise && (sel == SEL_ALL1);
   assign sw_rst   = wr_rise && (sel == SW'(SEL_MUX)) && (wdata[5:0] == MUX_RST_CODE);
   assign bank_rst = hw_rst || sw_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= DW'(DEF_MASK);
         page_q <= DW'(DEF_PAGE);
         gctl_q <= DW'(DEF_GCTL);
         mux_q  <= DW'(DEF_MUX);
         iclk_q <= DW'(DEF_ICLK);
         oclk_q <= DW'(DEF_OCLK);
         test_q <= DW'(DEF_TEST);
         clr_q  <= 1'b1;
      end else begin
         clr_q <= bank_rst;
         if (bank_rst) begin
            mask_q <= DW'(DEF_MASK);
            page_q <= DW'(DEF_PAGE);
            gctl_q <= DW'(DEF_GCTL);
            mux_q  <= DW'(DEF_MUX);
            iclk_q <= DW'(DEF_ICLK);
            oclk_q <= DW'(DEF_OCLK);
            test_q <= DW'(DEF_TEST);
         end else if (wr_rise) begin
            case (sel)
               SW'(SEL_MASK): mask_q <= wdata;
               SW'(SEL_PAGE): page_q <= wdata;
               SW'(SEL_GCTL): gctl_q <= wdata;
               SW'(SEL_ICLK): iclk_q <= wdata;
               SW'(SEL_OCLK): oclk_q <= wdata;
               SW'(SEL_MUX):  mux_q  <= wdata;
               SW'(SEL_TEST): test_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   // address and holding registers carry no defined reset value
   always_ff @(posedge clk) begin
      if (wr_rise && (sel == SW'(SEL_PADDR))) paddr_q <= wdata;
      if (wr_rise && (sel == SW'(SEL_HOLD)))  hold_q  <= wdata;
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SW'(SEL_PADDR): rdata = paddr_q;
         SW'(SEL_HOLD):  rdata = hold_q;
         SW'(SEL_MASK):  rdata = mask_q;
         SW'(SEL_PAGE):  rdata = page_q;
         SW'(SEL_GCTL):  rdata = gctl_q;
         SW'(SEL_ICLK):  rdata = iclk_q;
         SW'(SEL_OCLK):  rdata = oclk_q;
         SW'(SEL_MUX):   rdata = mux_q;
         SW'(SEL_TEST):  rdata = test_q;
         default:        rdata = '0;
      endcase
   end

   assign cnt_clr = clr_q;
endmodule

// File: rtl/vdc_pal_addr.sv
module vdc_pal_addr #(
   parameter int unsigned DW      = 8,
   parameter int unsigned PAGE_W  = 4,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] pix,
   input  logic [DW-1:0] page,
   input  logic [DW-1:0] mask,
   input  logic          nib_mode,
   output logic [DW-1:0] pal
);
   localparam int unsigned LOW_W = DW - PAGE_W;

   logic [DW-1:0] merged, gated;

   // page bits replace the upper pixel bits, then the mask gates the result
   assign merged = nib_mode ? {page[DW-1 -: PAGE_W], pix[LOW_W-1:0]} : pix;
   assign gated  = merged & mask;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pal <= '0;
            else        pal <= gated;
         end
      end else begin : g_comb
         assign pal = gated;
      end
   endgenerate
endmodule

// File: rtl/vdc_regbank.sv
module vdc_regbank
   import vdc_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned SW      = 4,
   parameter int unsigned PAGE_W  = 4,
   parameter int unsigned SYNC_N  = 2,
   parameter bit          REG_PAL = 1'b0
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic [SW-1:0] sel,
   input  logic [DW-1:0] wdata,
   input  logic          wr_strobe,
   input  logic [DW-1:0] pix_addr,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] pal_addr,
   output logic          cnt_clr
);
   generate
      if (DW < 8)                 begin : g_dw  $error("vdc_regbank: DW below 8"); end
      if (SW < 4)                 begin : g_sw  $error("vdc_regbank: SW below 4"); end
      if (PAGE_W == 0 || PAGE_W >= DW) begin : g_pg $error("vdc_regbank: bad PAGE_W"); end
      if (GCTL_NIB_BIT >= DW)     begin : g_nb  $error("vdc_regbank: nibble bit out of range"); end
   endgenerate

   logic rst_n_s;
   logic strobe_s, strobe_d, wr_rise;
   logic [DW-1:0] mask_q, page_q, gctl_q, mux_q;

   vdc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_por_sync (
      .clk(clk), .arst_n(por_n), .d(1'b1), .q(rst_n_s)
   );

   vdc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_wr_sync (
      .clk(clk), .arst_n(rst_n_s), .d(wr_strobe), .q(strobe_s)
   );

   always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) strobe_d <= 1'b0;
      else          strobe_d <= strobe_s;
   end

   assign wr_rise = strobe_s & ~strobe_d;

   vdc_regfile #(.DW(DW), .SW(SW)) u_regs (
      .clk(clk), .rst_n(rst_n_s), .wr_rise(wr_rise), .sel(sel), .wdata(wdata),
      .rdata(rdata), .mask_q(mask_q), .page_q(page_q), .gctl_q(gctl_q),
      .mux_q(mux_q), .cnt_clr(cnt_clr)
   );

   vdc_pal_addr #(.DW(DW), .PAGE_W(PAGE_W), .REG_OUT(REG_PAL)) u_pal (
      .clk(clk), .rst_n(rst_n_s), .pix(pix_addr), .page(page_q), .mask(mask_q),
      .nib_mode(gctl_q[GCTL_NIB_BIT]), .pal(pal_addr)
   );
endmodule

// File: rtl/vdc_regbank_chk.sv
module vdc_regbank_chk #(
   parameter int unsigned DW      = 8,
   parameter int unsigned SW      = 4,
   parameter bit          REG_PAL = 1'b0
) (
   input logic          clk,
   input logic          rst_n_s,
   input logic          wr_rise,
   input logic [SW-1:0] sel,
   input logic [DW-1:0] wdata,
   input logic [DW-1:0] mask_q,
   input logic [DW-1:0] mux_q,
   input logic [DW-1:0] gctl_q,
   input logic [DW-1:0] pal_addr,
   input logic          cnt_clr
);
   logic is_hw, is_sw;
   assign is_hw = wr_rise && (sel == {SW{1'b1}});
   assign is_sw = wr_rise && (sel == SW'(7)) && (wdata[5:0] == 6'h2D);

   p_write_mask_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
      (wr_rise && sel == SW'(2)) |=> (mask_q == $past(wdata)));

   p_unused_sel_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
      (wr_rise && sel >= SW'(9) && sel <= SW'(14)) |=>
         ($stable(mask_q) && $stable(mux_q) && $stable(gctl_q) && !cnt_clr));

   p_hw_reset_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
      is_hw |=> (mask_q == DW'(8'hFF) && mux_q == DW'(8'h2D) && gctl_q == DW'(8'h03)));

   p_sw_reset_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
      is_sw |=> (mux_q == DW'(8'h2D) && gctl_q == DW'(8'h03) && mask_q == DW'(8'hFF)));

   p_clr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
      (is_hw || is_sw) |=> cnt_clr);

   p_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
      !(is_hw || is_sw) |=> !cnt_clr);

   generate
      if (!REG_PAL) begin : g_comb_chk
         p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
            (mask_q == '0) |-> (pal_addr == '0));
      end else begin : g_reg_chk
         p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
            (mask_q == '0 && $past(mask_q) == '0) |-> (pal_addr == '0));
      end
   endgenerate
endmodule

bind vdc_regbank vdc_regbank_chk #(.DW(DW), .SW(SW), .REG_PAL(REG_PAL)) u_chk (
   .clk(clk), .rst_n_s(rst_n_s), .wr_rise(wr_rise), .sel(sel), .wdata(wdata),
   .mask_q(mask_q), .mux_q(mux_q), .gctl_q(gctl_q), .pal_addr(pal_addr),
   .cnt_clr(cnt_clr)
);

// File: tb/vdc_regbank_test.sv
module vdc_regbank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {gctl, page, mask, pix, expected pal}
   localparam logic [39:0] VEC [NVEC] = '{
      {8'h00, 8'hAB, 8'hFF, 8'h5C, 8'h5C},   // R8
      {8'h00, 8'hAB, 8'h0F, 8'h5C, 8'h0C},   // R8
      {8'h04, 8'hA0, 8'hFF, 8'h5C, 8'hAC},   // R9
      {8'h04, 8'h30, 8'hF3, 8'h7E, 8'h32},   // R9
      {8'h04, 8'hF0, 8'h00, 8'hFF, 8'h00},   // R10
      {8'h00, 8'hF0, 8'h00, 8'hFF, 8'h00}    // R10
   };

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [3:0] sel = '0;
   logic [7:0] wdata = '0;
   logic       wr_strobe = 1'b0;
   logic [7:0] pix_addr = '0;
   logic [7:0] rdata, pal_addr;
   logic       cnt_clr;

   int checks = 0;
   int fails  = 0;
   logic c1, c2;

   always #(CLK_PERIOD/2) clk = ~clk;

   vdc_regbank uut (
      .clk(clk), .por_n(por_n), .sel(sel), .wdata(wdata), .wr_strobe(wr_strobe),
      .pix_addr(pix_addr), .rdata(rdata), .pal_addr(pal_addr), .cnt_clr(cnt_clr)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [3:0] s, input logic [7:0] d,
                         output logic clr1, output logic clr2);
      @(negedge clk);
      sel = s; wdata = d; wr_strobe = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); clr1 = cnt_clr;
      @(negedge clk); clr2 = cnt_clr;
      wr_strobe = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic readback(input string req, input logic [3:0] s, input logic [7:0] exp);
      @(negedge clk);
      sel = s;
      #1 check(req, rdata, exp);
   endtask

   task automatic check_defaults(input string req);
      readback(req, 4'd7, 8'h2D);
      readback(req, 4'd5, 8'h00);
      readback(req, 4'd6, 8'h3F);
      readback(req, 4'd3, 8'h00);
      readback(req, 4'd4, 8'h03);
      readback(req, 4'd2, 8'hFF);
      readback(req, 4'd8, 8'h00);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1 / R7: power-on
      repeat (3) @(negedge clk);
      check("R7 clr during por", {7'd0, cnt_clr}, 8'd1);
      check_defaults("R1 during por");
      @(negedge clk); por_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R7 clr after por", {7'd0, cnt_clr}, 8'd0);
      check_defaults("R1 after por");

      // R2: plain writes and readback
      strobe(4'd0, 8'h5A, c1, c2);
      strobe(4'd1, 8'hA5, c1, c2);
      check("R7 no clr on write", {6'd0, c1, c2}, 8'd0);
      strobe(4'd5, 8'h11, c1, c2);
      strobe(4'd6, 8'h22, c1, c2);
      strobe(4'd8, 8'h01, c1, c2);
      readback("R2 paddr", 4'd0, 8'h5A);
      readback("R2 hold", 4'd1, 8'hA5);
      readback("R2 iclk", 4'd5, 8'h11);
      readback("R2 oclk", 4'd6, 8'h22);
      readback("R2 test", 4'd8, 8'h01);

      // R8/R9/R10: address vectors
      for (int i = 0; i < NVEC; i++) begin
         strobe(4'd4, VEC[i][39:32], c1, c2);
         strobe(4'd3, VEC[i][31:24], c1, c2);
         strobe(4'd2, VEC[i][23:16], c1, c2);
         @(negedge clk); pix_addr = VEC[i][15:8];
         #1 check($sformatf("R8/R9/R10 vec%0d", i), pal_addr, VEC[i][7:0]);
      end

      // R3: unused select
      strobe(4'd2, 8'h12, c1, c2);
      strobe(4'd9, 8'h77, c1, c2);
      check("R3 no clr", {7'd0, c1}, 8'd0);
      readback("R3 unused reads zero", 4'd9, 8'h00);
      readback("R3 unused reads zero", 4'd14, 8'h00);
      readback("R3 mask untouched", 4'd2, 8'h12);

      // R6: non-reset mux write
      strobe(4'd7, 8'h2C, c1, c2);
      check("R6 no clr", {7'd0, c1}, 8'd0);
      readback("R6 mux stored", 4'd7, 8'h2C);

      // R4: hardware reset
      strobe(4'd15, 8'h55, c1, c2);
      check("R7 hw clr pulse", {6'd0, c1, c2}, 8'b10);
      check_defaults("R4 hw defaults");
      readback("R4 hold kept", 4'd1, 8'hA5);

      // R5: software reset with upper bits set
      strobe(4'd4, 8'h07, c1, c2);
      strobe(4'd2, 8'h0F, c1, c2);
      strobe(4'd7, 8'hED, c1, c2);
      check("R7 sw clr pulse", {6'd0, c1, c2}, 8'b10);
      check_defaults("R5 sw defaults");

      // R11: held strobe acts once
      @(negedge clk); sel = 4'd5; wdata = 8'h33; wr_strobe = 1'b1;
      repeat (4) @(negedge clk);
      wdata = 8'h44;
      repeat (6) @(negedge clk);
      #1 check("R11 held strobe single action", rdata, 8'h33);
      wr_strobe = 1'b0;
      repeat (3) @(negedge clk);
      strobe(4'd5, 8'h44, c1, c2);
      readback("R11 new edge acts", 4'd5, 8'h44);

      // R1: power-on mid run
      strobe(4'd2, 8'h00, c1, c2);
      @(negedge clk); por_n = 1'b0;
      #1 check("R7 clr on por assert", {7'd0, cnt_clr}, 8'd1);
      check_defaults("R1 por mid run");
      @(negedge clk); por_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R7 clr after por release", {7'd0, cnt_clr}, 8'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule